// File: doc/BRIEF.md
# Log-Domain Masked Row Softmax

This block turns one row of attention scores into a row of probabilities. A row arrives on a wide parallel port together with one exclusion bit per element. A start pulse captures it. The block scales every score by one eighth, which is the reciprocal square root of a key width of 64. It then works through the row in four sequential passes: find the largest included score, accumulate the exponentials of the differences to it, take the natural logarithm of that sum, and produce each output as a single exponential. The division in softmax becomes a subtraction of the log-sum in the exponent.

The exponential is evaluated as a power of two. Its argument is multiplied by log2(e) with a shift-and-add, and 2^f is taken as 1+f on the fraction, with the integer part applied as a right shift. The logarithm uses a leading-one detector plus a linear mantissa, then a shift-and-add multiply by ln 2. The datapath has no multiplier, no divider and no table. Results stay on the output port until the next row completes.

Top module: `lse_softmax`

## Requirements
- R1: After reset `done_o` and `busy_o` are 0 and every element of `probs_o` is 0.
- R2: A `start_i` high at a rising edge while idle is accepted. `busy_o` is high from the next cycle. `done_o` pulses high for exactly one cycle, 3·ROW_LEN+1 rising edges after the accepting edge, and `busy_o` is low in that cycle.
- R3: `start_i`, `scores_i` and `mask_i` are ignored while busy. The row in progress completes with its original result and latency.
- R4: Element i of `scores_i` is the signed Q7.8 value in bits [16i+15:16i]. It is scaled by an arithmetic right shift by 3 before any other use.
- R5: A `mask_i` bit of 1 excludes that element. The element is skipped in the maximum search and in the sum, and its output is exactly 0.
- R6: exp(y) for y ≤ 0 in Q.8 is computed as follows. Take t = y + (y>>>1) − (y>>>4), then k = t>>>8 and f = t mod 256. The result in Q1.15 is ((256+f)·128) >> (−k), or 0 when −k > 16.
- R7: ln(S) of the Q1.15 sum S is computed as follows. Let p be the leading-one position of S. Then L = (p−15)·256 + ((S >> (p−8)) mod 256), and the result is (L>>1)+(L>>3)+(L>>4) in Q.8. It is 0 when S < 32768.
- R8: Output element i (bits [16i+15:16i], unsigned Q1.15, 0x8000 = 1.0) equals exp(s_i − m − ln(Σ exp(s_j − m))). Here s denotes scaled scores, m is the largest included scaled score, and the sum runs over included elements.
- R9: A row with every element excluded produces all-zero outputs and still completes normally.
- R10: A row with exactly one included element gives 0x8000 at that position and 0 elsewhere.
- R11: `probs_o` holds its value while idle, until the next row completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Row start request, sampled while idle |
| scores_i | input | ROW_LEN*IN_W | Row of signed Q7.8 scores, element i at bits [16i+15:16i] |
| mask_i | input | ROW_LEN | Exclusion bits, 1 = element left out |
| busy_o | output | 1 | A row is being processed |
| done_o | output | 1 | One-cycle pulse when a row's outputs are valid |
| probs_o | output | ROW_LEN*P_W | Row of Q1.15 probabilities, element i at bits [16i+15:16i] |

## Verification
The bench targets rows whose results can be worked out by hand. A row of identical scores gives 548 per element. Thirty-two included zeros next to huge excluded scores give 1084 each. A lone included element gives exactly 0x8000, and a fully excluded row gives zeros. Scores that differ only in their three low bits must behave as identical. A design that let excluded scores into the maximum, that dropped the scaling shift, or that took the log of an empty sum would move those constants, leave excluded outputs non-zero, or produce garbage on the fully excluded row. Extreme positive and negative scores exercise the deep-shift underflow to zero. A start pulse with new data injected mid-row catches a controller that re-captures input while busy.

// File: rtl/lse_softmax_pkg.sv
package lse_softmax_pkg;

    // Row processing phases, visited in this order for every row.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_MAX  = 3'd1,
        PH_SUM  = 3'd2,
        PH_LOG  = 3'd3,
        PH_OUT  = 3'd4
    } phase_e;

endpackage

// File: rtl/lse_exp2_unit.sv
// Exponential approximation: exp(y) = 2^(y*log2e), shift-add and linear mantissa.
module lse_exp2_unit #(
    parameter int Y_W  = 18,
    parameter int FRAC = 8,
    parameter int P_W  = 16
) (
    input  logic signed [Y_W-1:0] y_i,
    output logic        [P_W-1:0] p_o
);
    localparam int T_W = Y_W + 2;

    logic signed [T_W-1:0] y_ext;
    logic signed [T_W-1:0] t_val;
    logic signed [T_W-1:0] k_int;
    logic signed [T_W-1:0] neg_k;
    logic        [P_W-1:0] mant;

    always_comb begin
        y_ext = {{2{y_i[Y_W-1]}}, y_i};
        // y * 1.4375 as y + y/2 - y/16
        t_val = y_ext + (y_ext >>> 1) - (y_ext >>> 4);
        k_int = t_val >>> FRAC;
        neg_k = -k_int;
        // 2^f approximated by 1 + f, placed so that 1.0 lands on bit P_W-1
        mant  = P_W'({1'b1, t_val[FRAC-1:0]}) << (P_W - 1 - FRAC);
        if (int'(neg_k) > P_W) begin
            p_o = '0;
        end else begin
            p_o = mant >> neg_k;
        end
    end

endmodule

// File: rtl/lse_ln_unit.sv
// Natural log approximation: leading-one position plus linear mantissa, times ln2.
module lse_ln_unit #(
    parameter int S_W      = 22,
    parameter int FRAC     = 8,
    parameter int EXP_FRAC = 15,
    parameter int L_W      = 16
) (
    input  logic [S_W-1:0] s_i,
    output logic [L_W-1:0] ln_o
);
    localparam int LI_W = $clog2(S_W);

    logic [LI_W-1:0] lead;
    logic [S_W-1:0]  norm;
    logic [FRAC-1:0] frac_bits;
    logic [L_W-1:0]  l2;
    logic [LI_W-1:0] int_part;

    always_comb begin
        lead = '0;
        for (int b = 0; b < S_W; b++) begin
            if (s_i[b]) begin
                lead = LI_W'(b);
            end
        end
        norm      = s_i >> (lead - LI_W'(FRAC));
        frac_bits = norm[FRAC-1:0];
        int_part  = lead - LI_W'(EXP_FRAC);
        l2        = (L_W'(int_part) << FRAC) | L_W'(frac_bits);
        if (s_i < S_W'(1 << EXP_FRAC)) begin
            ln_o = '0;
        end else begin
            // ln2 ~ 0.5 + 0.125 + 0.0625
            ln_o = (l2 >> 1) + (l2 >> 3) + (l2 >> 4);
        end
    end

endmodule

// File: rtl/lse_softmax.sv
module lse_softmax
    import lse_softmax_pkg::*;
#(
    parameter int ROW_LEN  = 64,
    parameter int IN_W     = 16,
    parameter int FRAC     = 8,
    parameter int SCALE_SH = 3,
    parameter int P_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ROW_LEN*IN_W-1:0] scores_i,
    input  logic [ROW_LEN-1:0]      mask_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [ROW_LEN*P_W-1:0]  probs_o
);
    localparam int IDX_W    = $clog2(ROW_LEN);
    localparam int SUM_W    = P_W + IDX_W;
    localparam int Y_W      = IN_W + 2;
    localparam int L_W      = IN_W;
    localparam int EXP_FRAC = P_W - 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROW_LEN - 1);

    typedef struct packed {
        phase_e                  phase;
        logic [IDX_W-1:0]        idx;
        logic                    any;
        logic signed [IN_W-1:0]  mx;
        logic [SUM_W-1:0]        sum;
        logic [L_W-1:0]          lnv;
        logic                    done;
    } ctl_t;

    ctl_t                   c_d, c_q;
    logic signed [IN_W-1:0] score_d [ROW_LEN];
    logic signed [IN_W-1:0] score_q [ROW_LEN];
    logic [ROW_LEN-1:0]     mask_d, mask_q;
    logic [P_W-1:0]         prob_d [ROW_LEN];
    logic [P_W-1:0]         prob_q [ROW_LEN];

    logic signed [IN_W-1:0] cur_s;
    logic                   cur_m;
    logic                   last;
    logic signed [Y_W-1:0]  s_x, m_x, l_x, exp_y;
    logic [P_W-1:0]         exp_p;
    logic [L_W-1:0]         ln_val;

    lse_exp2_unit #(.Y_W(Y_W), .FRAC(FRAC), .P_W(P_W)) u_exp (
        .y_i (exp_y),
        .p_o (exp_p)
    );

    lse_ln_unit #(.S_W(SUM_W), .FRAC(FRAC), .EXP_FRAC(EXP_FRAC), .L_W(L_W)) u_ln (
        .s_i  (c_q.sum),
        .ln_o (ln_val)
    );

    // Operand selection for the shared exponential unit
    always_comb begin
        cur_s = score_q[c_q.idx];
        cur_m = mask_q[c_q.idx];
        last  = (c_q.idx == LAST_IDX);
        s_x   = {{(Y_W-IN_W){cur_s[IN_W-1]}}, cur_s};
        m_x   = {{(Y_W-IN_W){c_q.mx[IN_W-1]}}, c_q.mx};
        l_x   = {{(Y_W-L_W){1'b0}}, c_q.lnv};
        if (c_q.phase == PH_OUT) begin
            exp_y = s_x - m_x - l_x;
        end else begin
            exp_y = s_x - m_x;
        end
    end

    // Next-state computation
    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        score_d  = score_q;
        mask_d   = mask_q;
        prob_d   = prob_q;
        unique case (c_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    for (int i = 0; i < ROW_LEN; i++) begin
                        score_d[i] = $signed(scores_i[i*IN_W +: IN_W]) >>> SCALE_SH;
                    end
                    mask_d    = mask_i;
                    c_d.phase = PH_MAX;
                    c_d.idx   = '0;
                    c_d.any   = 1'b0;
                    c_d.mx    = '0;
                    c_d.sum   = '0;
                    c_d.lnv   = '0;
                end
            end
            PH_MAX: begin
                if (!cur_m && (!c_q.any || cur_s > c_q.mx)) begin
                    c_d.mx  = cur_s;
                    c_d.any = 1'b1;
                end
                c_d.idx = c_q.idx + 1'b1;
                if (last) begin
                    c_d.phase = PH_SUM;
                    c_d.idx   = '0;
                end
            end
            PH_SUM: begin
                if (!cur_m) begin
                    c_d.sum = c_q.sum + SUM_W'(exp_p);
                end
                c_d.idx = c_q.idx + 1'b1;
                if (last) begin
                    c_d.phase = PH_LOG;
                    c_d.idx   = '0;
                end
            end
            PH_LOG: begin
                c_d.lnv   = ln_val;
                c_d.phase = PH_OUT;
                c_d.idx   = '0;
            end
            PH_OUT: begin
                prob_d[c_q.idx] = cur_m ? '0 : exp_p;
                c_d.idx = c_q.idx + 1'b1;
                if (last) begin
                    c_d.phase = PH_IDLE;
                    c_d.idx   = '0;
                    c_d.done  = 1'b1;
                end
            end
            default: begin
                c_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            mask_q <= '0;
            for (int i = 0; i < ROW_LEN; i++) begin
                score_q[i] <= '0;
                prob_q[i]  <= '0;
            end
        end else begin
            c_q     <= c_d;
            mask_q  <= mask_d;
            score_q <= score_d;
            prob_q  <= prob_d;
        end
    end

    for (genvar g = 0; g < ROW_LEN; g++) begin : g_out
        assign probs_o[g*P_W +: P_W] = prob_q[g];
    end

    assign busy_o = (c_q.phase != PH_IDLE);
    assign done_o = c_q.done;

    // ---------------- assertions ----------------
    logic exp_live;
    assign exp_live = ((c_q.phase == PH_SUM) || (c_q.phase == PH_OUT)) && !cur_m;

    // R6
    exp_arg_nonpos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_live |-> (exp_y <= 0));

    // R6
    exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_live |-> (exp_p <= P_W'(1 << EXP_FRAC)));

    // R7
    sum_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase == PH_LOG && c_q.any) |-> (c_q.sum >= SUM_W'(1 << EXP_FRAC)));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(mask_q));

    // R11
    prob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(probs_o));

endmodule

// File: tb/tb_lse_softmax.sv
`timescale 1ns/1ps
module tb_lse_softmax;
    localparam int N  = 64;
    localparam int W  = 16;
    localparam int LAT = 3*N + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [N*W-1:0] scores_i = '0;
    logic [N-1:0]   mask_i = '0;
    logic           busy_o, done_o;
    logic [N*W-1:0] probs_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int expv [N];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lse_softmax dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .scores_i(scores_i),
        .mask_i(mask_i), .busy_o(busy_o), .done_o(done_o), .probs_o(probs_o)
    );

    // exp approximation per R6
    function automatic int exp2a(int y);
        int t, k, f, nk;
        t  = y + (y >>> 1) - (y >>> 4);
        k  = t >>> 8;
        f  = t & 255;
        nk = -k;
        if (nk > 16) return 0;
        return ((256 + f) << 7) >> nk;
    endfunction

    // ln approximation per R7
    function automatic int lna(int s);
        int p, l2;
        if (s < 32768) return 0;
        p = 0;
        for (int b = 0; b < 31; b++) if (s[b]) p = b;
        l2 = ((p - 15) << 8) + ((s >> (p - 8)) & 255);
        return (l2 >> 1) + (l2 >> 3) + (l2 >> 4);
    endfunction

    // reference row per R4, R5, R8
    task automatic model_row(input logic [N*W-1:0] sc, input logic [N-1:0] mk);
        int s [N];
        int m, sum, lv;
        bit any;
        any = 0; m = 0; sum = 0;
        for (int i = 0; i < N; i++) begin
            s[i] = int'($signed(sc[i*W +: W])) >>> 3;
            if (!mk[i] && (!any || s[i] > m)) begin m = s[i]; any = 1; end
        end
        for (int i = 0; i < N; i++) if (!mk[i]) sum += exp2a(s[i] - m);
        lv = lna(sum);
        for (int i = 0; i < N; i++) expv[i] = mk[i] ? 0 : exp2a(s[i] - m - lv);
    endtask

    task automatic check_row(input string tag);
        int bad;
        bad = -1;
        for (int i = 0; i < N; i++)
            if (bad < 0 && int'(probs_o[i*W +: W]) != expv[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s element %0d: got %0d expected %0d", tag, bad,
                     probs_o[bad*W +: W], expv[bad]);
        end
    endtask

    task automatic check_val(input string tag, input int got, input int want);
        checks++;
        if (got != want) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, want);
        end
    endtask

    // run one row; inject a competing start mid-row when asked (R3)
    task automatic run_row(input logic [N*W-1:0] sc, input logic [N-1:0] mk,
                           input bit inject);
        int cnt;
        bit seen_busy;
        @(negedge clk);
        scores_i = sc; mask_i = mk; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 0; seen_busy = 1'b1;
        forever begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            start_i = 1'b0;
            if (cnt < LAT && !busy_o) seen_busy = 1'b0;
            if (inject && cnt == 40) begin
                start_i  = 1'b1;
                mask_i   = ~mk;
                for (int i = 0; i < N; i++) scores_i[i*W +: W] = W'($urandom);
            end
            if (done_o || cnt > LAT + 20) break;
        end
        // R2: latency and busy during the row
        check_val(inject ? "R3 latency with ignored start" : "R2 done latency", cnt, LAT);
        check_val("R2 busy high while processing", int'(seen_busy), 1);
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [N*W-1:0] sc;
        logic [N-1:0]   mk;
        logic [N*W-1:0] held;
        int seed_init;
        seed_init = $urandom(32'd20240611);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check_val("R1 done after reset", int'(done_o), 0);
        check_val("R1 busy after reset", int'(busy_o), 0);
        check_val("R1 probs after reset", int'(probs_o == '0), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6 R7 R8: uniform row of zeros -> 548 each (hand computed)
        run_row('0, '0, 1'b0);
        for (int i = 0; i < N; i++) expv[i] = 548;
        check_row("R8 uniform row");

        // R4: low three bits vanish in the scale shift -> same as uniform
        for (int i = 0; i < N; i++) sc[i*W +: W] = W'($urandom_range(0, 7));
        run_row(sc, '0, 1'b0);
        check_row("R4 sub-shift scores treated as equal");

        // R5: 32 included zeros, excluded elements carry huge scores -> 1084
        for (int i = 0; i < N; i++) begin
            mk[i] = i[0];
            sc[i*W +: W] = i[0] ? 16'h7FFF : 16'h0000;
            expv[i] = i[0] ? 0 : 1084;
        end
        run_row(sc, mk, 1'b0);
        check_row("R5 excluded elements skipped and zeroed");

        // R10: exactly one included element
        for (int i = 0; i < N; i++) sc[i*W +: W] = W'($urandom);
        mk = '1; mk[17] = 1'b0;
        for (int i = 0; i < N; i++) expv[i] = (i == 17) ? 32768 : 0;
        run_row(sc, mk, 1'b0);
        check_row("R10 single included element");

        // R9: everything excluded (previous outputs were non-zero)
        for (int i = 0; i < N; i++) expv[i] = 0;
        run_row(sc, '1, 1'b0);
        check_row("R9 fully excluded row");

        // R8: extremes, underflow to zero on deep shifts
        for (int i = 0; i < N; i++) sc[i*W +: W] = (i % 3 == 0) ? 16'h7FFF : 16'h8000;
        run_row(sc, '0, 1'b0);
        model_row(sc, '0);
        check_row("R8 extreme scores");

        // R11: outputs held while idle
        held = probs_o;
        repeat (7) @(negedge clk);
        check_val("R11 outputs held while idle", int'(probs_o == held), 1);

        // R3: competing start with new data during a row
        for (int i = 0; i < N; i++) sc[i*W +: W] = W'($urandom_range(0, 4095));
        mk = N'({$urandom, $urandom}) & N'({$urandom, $urandom});
        model_row(sc, mk);
        run_row(sc, mk, 1'b1);
        check_row("R3 row unaffected by start while busy");

        // R5 R6 R7 R8: constrained random rows
        for (int r = 0; r < 16; r++) begin
            for (int i = 0; i < N; i++) begin
                if (r < 8) sc[i*W +: W] = W'($urandom_range(0, 3000));
                else       sc[i*W +: W] = W'($urandom);
            end
            mk = N'({$urandom, $urandom});
            if (r % 4 == 0) mk = '0;
            model_row(sc, mk);
            run_row(sc, mk, 1'b0);
            check_row("R8 random row");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule